// File: doc/BRIEF.md
# QoS Context Save/Restore Engine

This block keeps the quality-of-service settings of a group of bus ports alive across a power cycle of the domain that holds them. Before the domain is switched off, the power sequencer strobes a save: the engine, acting as a simple register-bus master, reads five configuration registers from every port and keeps the values in an internal context store. After power returns and the sequencer has released the domain's idle request, it strobes a restore, and the engine writes the stored values back in the same order.

Ports are visited from index 0 up to `NUM_PORTS-1`. Each port has a base address taken from the `PORT_BASE` parameter array. Within a port, the five registers are visited in a fixed order, and each has a fixed offset from the base. Every bus access is held steady until the slave returns ready. When the last access finishes, the engine returns a one-cycle done pulse to the sequencer. The sequencer must wait for this pulse before it raises the idle request for power-down. A configuration with no ports answers a strobe with done alone, and the bus stays quiet.

State machine: `ST_IDLE` waits for a strobe. `ST_SAVE_RD` issues reads. `ST_RESTORE_WR` issues writes. `ST_FINISH` raises done for one cycle.

The transitions are:
- From idle, a save strobe leads to `ST_SAVE_RD`, or to `ST_FINISH` when there are no ports.
- From idle, a restore strobe without a save strobe leads to `ST_RESTORE_WR`, or to `ST_FINISH` when there are no ports.
- An access state moves to `ST_FINISH` on the handshake of its last access.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `qos_ctx_engine`

## Requirements
- R1: After reset, done, the read strobe and the write strobe are low. The context store holds zero, so a restore issued before any save writes 0 to every register.
- R2: A save reads, for each port p from 0 to NUM_PORTS-1, the addresses PORT_BASE[p]+0x08 (priority), +0x0C (mode), +0x10 (bandwidth), +0x14 (saturation) and +0x18 (extended control), in that order, one access per register.
- R3: A restore writes the same addresses in the same order as a save. The data written to each address is the value read from that address by the most recent save.
- R4: At most one of the read and write strobes is high at a time. An access keeps its strobe, address and write data unchanged until a clock edge at which ready is high.
- R5: Done is high for exactly one cycle, in the cycle after the clock edge that completes the final handshake. No bus strobe is high while done is high.
- R6: With NUM_PORTS = 0, done is high in the cycle after the strobe is sampled, and neither bus strobe is ever raised.
- R7: Save and restore strobes that arrive while an operation is in progress have no effect: no extra accesses and no extra done pulse.
- R8: When save and restore strobes are both high in the same idle cycle, a save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_go | input | 1 | Start a save (one-cycle strobe from the power sequencer) |
| restore_go | input | 1 | Start a restore (one-cycle strobe from the power sequencer) |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled when ready is high |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_ready | input | 1 | Slave completes the current access |

## Verification
The bench drives a three-port configuration against a slave whose ready latency cycles through zero, one and two wait states. It checks every address and data word of full save and restore passes against values it computes from the port bases and a seed. A walker that skips a register, advances on a missing ready, or wraps at the wrong port shows up as an address mismatch or a wrong access count.

A restore taken right after reset checks that the store is cleared, since one that is not would write stale data. Two saves with different seeds check that a restore replays only the latest save. Strobes injected in the middle of a save, and a save and a restore strobe raised together, would otherwise show up as a second done pulse or as writes mixed into the reads. A second instance with no ports checks that done arrives one cycle after the strobe and that no bus strobe is ever raised, where an engine that entered an access state would hang or cause bus traffic.

// File: rtl/qos_ctx_pkg.sv
package qos_ctx_pkg;

    localparam int MAX_QOS_PORTS = 8;
    localparam int QOS_REGS      = 5;
    localparam int QOS_FIRST_OFS = 8;
    localparam int QOS_STRIDE    = 4;
    localparam int PORT_IW       = $clog2(MAX_QOS_PORTS);
    localparam int REG_IW        = $clog2(QOS_REGS);
    localparam int SLOT_IW       = $clog2(MAX_QOS_PORTS * QOS_REGS);

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SAVE_RD    = 2'd1,
        ST_RESTORE_WR = 2'd2,
        ST_FINISH     = 2'd3
    } qos_state_e;

    // Register offset within a port: priority, mode, bandwidth,
    // saturation, extended control at 0x08..0x18.
    function automatic logic [7:0] qos_reg_offset(input logic [REG_IW-1:0] r);
        return 8'(QOS_FIRST_OFS + QOS_STRIDE * int'(r));
    endfunction

endpackage

// File: rtl/qos_ctx_walker.sv
module qos_ctx_walker
    import qos_ctx_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    output logic [PORT_IW-1:0] port_idx,
    output logic [REG_IW-1:0]  reg_idx,
    output logic               last
);

    logic [PORT_IW-1:0] port_q;
    logic [REG_IW-1:0]  reg_q;
    logic               reg_wrap;

    assign reg_wrap = (reg_q == REG_IW'(QOS_REGS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            port_q <= '0;
            reg_q  <= '0;
        end else if (step) begin
            if (reg_wrap) begin
                reg_q  <= '0;
                port_q <= port_q + 1'b1;
            end else begin
                reg_q <= reg_q + 1'b1;
            end
        end
    end

    assign port_idx = port_q;
    assign reg_idx  = reg_q;
    assign last     = reg_wrap && (int'(port_q) == NUM_PORTS - 1);

endmodule

// File: rtl/qos_ctx_store.sv
module qos_ctx_store
    import qos_ctx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_IW-1:0] slot,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata
);

    localparam int DEPTH = MAX_QOS_PORTS * QOS_REGS;

    logic [DW-1:0] ctx_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctx_mem[i] <= '0;
        end else if (wr_en) begin
            ctx_mem[slot] <= wdata;
        end
    end

    assign rdata = ctx_mem[slot];

endmodule

// File: rtl/qos_ctx_engine.sv
module qos_ctx_engine
    import qos_ctx_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int NUM_PORTS = 3,
    parameter logic [MAX_QOS_PORTS-1:0][AW-1:0] PORT_BASE = {
        32'h0000_7000, 32'h0000_6000, 32'h0000_5000, 32'h0000_4000,
        32'h0000_3000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_go,
    input  logic          restore_go,
    output logic          done,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic          bus_ready
);

    localparam bit HAS_PORTS = (NUM_PORTS > 0);

    qos_state_e state_q, state_d;

    logic [PORT_IW-1:0] port_idx;
    logic [REG_IW-1:0]  reg_idx;
    logic               last_acc;
    logic               in_access;
    logic               handshake;
    logic [SLOT_IW-1:0] slot;
    logic [DW-1:0]      held_val;
    logic [AW-1:0]      acc_addr;

    assign in_access = (state_q == ST_SAVE_RD) || (state_q == ST_RESTORE_WR);
    assign handshake = in_access && bus_ready;
    assign slot      = SLOT_IW'(port_idx) * SLOT_IW'(QOS_REGS) + SLOT_IW'(reg_idx);
    assign acc_addr  = PORT_BASE[port_idx] + AW'(qos_reg_offset(reg_idx));

    qos_ctx_walker #(.NUM_PORTS(NUM_PORTS)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_IDLE),
        .step     (handshake),
        .port_idx (port_idx),
        .reg_idx  (reg_idx),
        .last     (last_acc)
    );

    qos_ctx_store #(.DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (state_q == ST_SAVE_RD && bus_ready),
        .slot  (slot),
        .wdata (bus_rdata),
        .rdata (held_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (save_go)
                    state_d = HAS_PORTS ? ST_SAVE_RD : ST_FINISH;
                else if (restore_go)
                    state_d = HAS_PORTS ? ST_RESTORE_WR : ST_FINISH;
            end
            ST_SAVE_RD, ST_RESTORE_WR: begin
                if (bus_ready && last_acc) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        done      = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SAVE_RD: begin
                bus_rd   = 1'b1;
                bus_addr = acc_addr;
            end
            ST_RESTORE_WR: begin
                bus_wr    = 1'b1;
                bus_addr  = acc_addr;
                bus_wdata = held_val;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/qos_ctx_checker.sv
module qos_ctx_checker #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int NUM_PORTS = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          save_go,
    input logic          restore_go,
    input logic          done,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          bus_ready
);

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

    a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(bus_rd || bus_wr));

    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rose_ok && done && NUM_PORTS > 0) |-> $past(bus_ready && (bus_rd || bus_wr)));

    a_r6_zero_ports_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_PORTS == 0) |-> !(bus_rd || bus_wr));

    a_r6_zero_ports_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rose_ok && done && NUM_PORTS == 0) |-> $past(save_go || restore_go));

    // One cycle of history after reset before $past is trusted.
    logic rose_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) rose_ok <= 1'b0;
        else        rose_ok <= 1'b1;
    end

endmodule

bind qos_ctx_engine qos_ctx_checker #(.AW(AW), .DW(DW), .NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_go    (save_go),
    .restore_go (restore_go),
    .done       (done),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_ready  (bus_ready)
);

// File: tb/sim_qos_ctx_engine.sv
`timescale 1ns/1ps
module sim_qos_ctx_engine;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NP = 3;
    localparam int NACC = NP * 5;

    function automatic logic [31:0] base_of(input int p);
        return 32'h4000_0020 + 32'(p) * 32'h0000_0400;
    endfunction

    localparam logic [7:0][31:0] BASES = {
        base_of(7), base_of(6), base_of(5), base_of(4),
        base_of(3), base_of(2), base_of(1), base_of(0)};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          save_go = 1'b0, restore_go = 1'b0, done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_wr, bus_rd, bus_ready;

    qos_ctx_engine #(.AW(AW), .DW(DW), .NUM_PORTS(NP), .PORT_BASE(BASES)) u0 (
        .clk(clk), .rst_n(rst_n), .save_go(save_go), .restore_go(restore_go),
        .done(done), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ready(bus_ready));

    logic          z_save = 1'b0, z_restore = 1'b0, z_done, z_wr, z_rd;
    logic [AW-1:0] z_addr;
    logic [DW-1:0] z_wdata;

    qos_ctx_engine #(.AW(AW), .DW(DW), .NUM_PORTS(0), .PORT_BASE(BASES)) u1 (
        .clk(clk), .rst_n(rst_n), .save_go(z_save), .restore_go(z_restore),
        .done(z_done), .bus_addr(z_addr), .bus_wdata(z_wdata),
        .bus_rdata('0), .bus_wr(z_wr), .bus_rd(z_rd), .bus_ready(1'b0));

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Bus slave: read data = addr ^ seed, latency cycles 0,1,2 wait states.
    logic [31:0] seed = '0;
    logic [31:0] cap_addr, cap_wdata;
    logic        cap_wr;
    int          lat = 0, acc_total = 0, log_n = 0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_wr   [64];

    initial begin
        bus_ready = 1'b0;
        bus_rdata = '0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            lat       <= 0;
        end else if (bus_ready) begin
            if (log_n < 64) begin
                log_addr[log_n] <= cap_addr;
                log_data[log_n] <= cap_wr ? cap_wdata : (cap_addr ^ seed);
                log_wr[log_n]   <= cap_wr;
            end
            log_n     <= log_n + 1;
            acc_total <= acc_total + 1;
            bus_ready <= 1'b0;
            lat       <= 0;
        end else if (bus_rd || bus_wr) begin
            if (lat == acc_total % 3) begin
                bus_ready <= 1'b1;
                bus_rdata <= bus_addr ^ seed;
                cap_addr  <= bus_addr;
                cap_wr    <= bus_wr;
                cap_wdata <= bus_wdata;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    int done_cnt = 0;
    int z_act = 0;
    always @(negedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (z_rd || z_wr) z_act <= z_act + 1;
    end

    function automatic logic [31:0] exp_addr(input int k);
        return base_of(k / 5) + 32'(8 + 4 * (k % 5));
    endfunction

    task automatic run_op(input bit do_save, input bit do_restore,
                          input logic [31:0] new_seed, input bit inject, input string tag);
        int  d0;
        int  cyc;
        bit  seen;
        if (do_save) seed = new_seed;
        log_n = 0;
        d0 = done_cnt;
        @(negedge clk);
        save_go = do_save;
        restore_go = do_restore;
        @(negedge clk);
        save_go = 1'b0;
        restore_go = 1'b0;
        cyc = 0;
        seen = 0;
        while (!seen && cyc < 400) begin
            if (inject && (cyc == 5 || cyc == 9)) begin
                save_go = 1'b1;
                restore_go = 1'b1;
            end else begin
                save_go = 1'b0;
                restore_go = 1'b0;
            end
            if (done) begin
                seen = 1;
                check(!bus_rd && !bus_wr, {tag, " R5 bus quiet with done"},
                      {30'd0, bus_rd, bus_wr}, 32'd0);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        save_go = 1'b0;
        restore_go = 1'b0;
        check(seen, {tag, " R5 done seen"}, 32'(seen), 32'd1);
        @(negedge clk);
        check(!done, {tag, " R5 done one cycle"}, 32'(done), 32'd0);
        repeat (12) @(negedge clk);
        check(done_cnt - d0 == 1, {tag, " R5 R7 single done"}, 32'(done_cnt - d0), 32'd1);
        check(log_n == NACC, {tag, " access count"}, 32'(log_n), 32'(NACC));
    endtask

    task automatic verify_log(input bit exp_wr, input logic [31:0] data_seed,
                              input bit zero_data, input string tag);
        for (int k = 0; k < NACC; k++) begin
            check(log_addr[k] == exp_addr(k), {tag, " R2 R3 address order"},
                  log_addr[k], exp_addr(k));
            check(log_wr[k] == exp_wr, {tag, " R8 access kind"},
                  32'(log_wr[k]), 32'(exp_wr));
            if (exp_wr) begin
                if (zero_data)
                    check(log_data[k] == 32'd0, {tag, " R1 cleared store"},
                          log_data[k], 32'd0);
                else
                    check(log_data[k] == (exp_addr(k) ^ data_seed),
                          {tag, " R3 restored value"},
                          log_data[k], exp_addr(k) ^ data_seed);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !bus_rd && !bus_wr, "R1 reset outputs",
              {29'd0, done, bus_rd, bus_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !bus_rd && !bus_wr && !z_done, "R1 outputs after reset",
              {28'd0, z_done, done, bus_rd, bus_wr}, 32'd0);

        // R1: restore before any save writes zeros
        run_op(0, 1, 32'h0, 0, "restore-empty");
        verify_log(1, 32'h0, 1, "restore-empty");

        // R2: save with seed A, then R3 restore
        run_op(1, 0, 32'h5A5A_0F0F, 0, "save-A");
        verify_log(0, 32'h0, 0, "save-A");
        run_op(0, 1, 32'h0, 0, "restore-A");
        verify_log(1, 32'h5A5A_0F0F, 0, "restore-A");

        // R7: strobes during a save are ignored
        run_op(1, 0, 32'h1234_8765, 1, "save-B busy");
        verify_log(0, 32'h0, 0, "save-B busy");
        run_op(0, 1, 32'h0, 1, "restore-B busy");
        verify_log(1, 32'h1234_8765, 0, "restore-B busy");

        // R8: both strobes together -> save
        run_op(1, 1, 32'hC3C3_3C3C, 0, "both-C");
        verify_log(0, 32'h0, 0, "both-C");
        run_op(0, 1, 32'h0, 0, "restore-C");
        verify_log(1, 32'hC3C3_3C3C, 0, "restore-C");

        // R6: zero-port instance
        @(negedge clk);
        z_save = 1'b1;
        @(negedge clk);
        z_save = 1'b0;
        check(z_done, "R6 zero-port save done next cycle", 32'(z_done), 32'd1);
        @(negedge clk);
        check(!z_done, "R6 zero-port done one cycle", 32'(z_done), 32'd0);
        z_restore = 1'b1;
        @(negedge clk);
        z_restore = 1'b0;
        check(z_done, "R6 zero-port restore done next cycle", 32'(z_done), 32'd1);
        repeat (4) @(negedge clk);
        check(z_act == 0, "R6 zero-port no bus traffic", 32'(z_act), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule